// File: doc/BRIEF.md
# Cache Block Touch Prefetch Issuer

This block sits between instruction decode and the request port of a data cache. It watches each decoded instruction word and recognises the two cache-touch hints: one that announces a coming read of a line and one that announces a coming store to it. For either hint it adds the two register operands to form the effective address, clears the offset bits within a 128-byte line, and posts one prefetch request. Each request carries the fill state it wants: exclusive for the store hint, so that the later store needs no ownership upgrade, and shared for the read hint.

A hint creates no architectural obligation. Requests whose address translation reports an unmapped or protected page are dropped silently, with no fault and no error output. The request channel holds one entry. When a new hint arrives while the held request has not been taken, the new hint is discarded, so decode never stalls. The instructions write no general-purpose register and no status bits, so the block has no result path.

Top module: `touch_prefetch_issuer`

## Requirements
- R1: A valid word with bits 31:26 equal to 31 and bits 10:1 equal to 246 (the store hint, 0x7c0001ec when all register fields are zero) produces one request with `pf_excl` = 1.
- R2: A valid word with bits 31:26 equal to 31 and bits 10:1 equal to 278 (the read hint) produces one request with `pf_excl` = 0.
- R3: Any other word, including primary 31 with another extended opcode and another primary with extended opcode 246 or 278, produces no request.
- R4: When the RA field (bits 20:16) is 0, the base is the constant zero and `opnd_a` has no effect. The line address then comes from `opnd_b` alone.
- R5: Otherwise the address is `opnd_a + opnd_b`, modulo 2^64, with bits 6:0 forced to zero.
- R6: If `xlate_unmapped` or `xlate_protect` is high with the hint, no request is made and no other output changes.
- R7: An accepted hint shows up on `pf_vld` one clock after it is presented. The request stays unchanged until a cycle with `pf_rdy` high, and it is gone in the next cycle unless a new hint replaces it.
- R8: A hint that arrives while the held request is not taken in that cycle is discarded. A hint that arrives in the cycle the held request is taken replaces it at once.
- R9: The RT field (bits 25:21) and the Rc bit (bit 0) do not affect recognition, address or fill state.
- R10: While `rst_n` is low at a clock edge, any held request is cleared, and `pf_vld` is 0 in the next cycle.
- R11: With `insn_vld` low, the word and operands are ignored and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_vld | input | 1 | Decoded instruction word is present |
| insn_word | input | 32 | Instruction word, bit 31 = most significant |
| opnd_a | input | 64 | Contents of the register named by RA |
| opnd_b | input | 64 | Contents of the register named by RB |
| xlate_unmapped | input | 1 | Translation found no mapping for the address |
| xlate_protect | input | 1 | Translation denied access to the address |
| pf_rdy | input | 1 | Cache accepts the held request |
| pf_vld | output | 1 | Prefetch request is held |
| pf_addr | output | 64 | Line-aligned request address |
| pf_excl | output | 1 | 1 = exclusive fill, 0 = shared fill |

## Verification
The hardest situation to bring about from the ports is a collision in the single request slot. A second hint has to arrive while the first is still held, and the outcome depends on whether `pf_rdy` is high in that same cycle. The bench holds `pf_rdy` low, issues a store hint and then a read hint at another address, and checks that the first request stays in place. It then raises `pf_rdy` in the same cycle as a third hint and checks that the third takes the slot straight away. Before that, full sweeps over every extended opcode under primary 31, every primary under both touch opcodes, and every RA number check decoding and address forming against values computed in the bench.

// File: rtl/touch_pkg.sv
// Package: shared types and constants for the cache-touch prefetch issuer.
// Assumes 32-bit instruction words with big-endian field numbering, so
// bit 0 of the field description is bit 31 of the vector.
package touch_pkg;

    // Field positions inside the instruction word (vector numbering).
    localparam int PRI_HI = 31;
    localparam int PRI_LO = 26;
    localparam int RA_HI  = 20;
    localparam int RA_LO  = 16;
    localparam int XO_HI  = 10;
    localparam int XO_LO  = 1;

    localparam int PRI_W  = PRI_HI - PRI_LO + 1;
    localparam int RA_W   = RA_HI - RA_LO + 1;
    localparam int XO_W   = XO_HI - XO_LO + 1;

    // Kind of touch hint found by the decoder.
    typedef enum logic [1:0] {
        HINT_NONE  = 2'd0,
        HINT_READ  = 2'd1,
        HINT_STORE = 2'd2
    } hint_kind_e;

    // Decoded fields handed from decode to address generation.
    typedef struct packed {
        hint_kind_e        kind;
        logic              ra_is_zero;
    } hint_dec_t;

endpackage

// File: rtl/touch_decode.sv
// Module: touch_decode
// Recognises the read-intent and store-intent cache-touch words from the
// primary and extended opcode fields. It ignores the destination field and
// the record bit. Purely combinational; assumes the word is stable while
// insn_vld is high.
module touch_decode
    import touch_pkg::*;
#(
    parameter int unsigned PRI_TOUCH = 31,
    parameter int unsigned XO_RD     = 278,
    parameter int unsigned XO_ST     = 246
) (
    input  logic        vld,
    input  logic [31:0] word,
    output hint_dec_t   dec
);

    logic [PRI_W-1:0] pri;
    logic [XO_W-1:0]  xo;
    logic [RA_W-1:0]  ra;

    // Slice the fields the decision depends on.
    always_comb begin
        pri = word[PRI_HI:PRI_LO];
        xo  = word[XO_HI:XO_LO];
        ra  = word[RA_HI:RA_LO];
    end

    // Classify the word; anything else is not a hint.
    always_comb begin
        dec.kind       = HINT_NONE;
        dec.ra_is_zero = (ra == '0);
        if (vld && pri == PRI_W'(PRI_TOUCH)) begin
            if (xo == XO_W'(XO_ST))
                dec.kind = HINT_STORE;
            else if (xo == XO_W'(XO_RD))
                dec.kind = HINT_READ;
        end
    end

    // R3: a word whose primary field differs can never be a hint.
    always_comb begin
        a_r3_foreign_primary: assert (!(pri != PRI_W'(PRI_TOUCH) && dec.kind != HINT_NONE));
    end

endmodule

// File: rtl/touch_ea.sv
// Module: touch_ea
// Forms the effective address from the base and index operands and clears
// the offset inside one cache line. A base register number of zero selects
// the constant zero. Combinational; LINE_BYTES must be a power of two.
module touch_ea #(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned LINE_BYTES = 128
) (
    input  logic              base_zero,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic [ADDR_W-1:0] line_addr
);

    localparam int unsigned OFFS_W = $clog2(LINE_BYTES);

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] sum;

    // Choose the base operand and add the index, wrapping at 2^ADDR_W.
    always_comb begin
        base_sel = base_zero ? '0 : base_val;
        sum      = base_sel + index_val;
    end

    // Drop the line offset bits, or pass through for one-byte lines.
    generate
        if (OFFS_W == 0) begin : g_no_offs
            assign line_addr = sum;
        end else begin : g_offs
            assign line_addr = {sum[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/touch_req_slot.sv
// Module: touch_req_slot
// Single-entry request register for the prefetch channel. A new hint loads
// only when the slot is empty or its occupant is taken in the same cycle;
// otherwise the hint is dropped. Synchronous active-low reset.
module touch_req_slot #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hint_ok,
    input  logic [ADDR_W-1:0] hint_addr,
    input  logic              hint_excl,
    input  logic              rdy,
    output logic              vld,
    output logic [ADDR_W-1:0] addr,
    output logic              excl
);

    logic free;
    logic load;

    // The slot can take a hint when empty or when emptied this cycle.
    always_comb begin
        free = !vld || rdy;
        load = hint_ok && free;
    end

    // Hold, replace or retire the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            addr <= '0;
            excl <= 1'b0;
        end else if (load) begin
            vld  <= 1'b1;
            addr <= hint_addr;
            excl <= hint_excl;
        end else if (rdy) begin
            vld  <= 1'b0;
        end
    end

    // R7: a request not taken stays unchanged.
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !rdy |=> vld && $stable(addr) && $stable(excl));

    // R8: a hint meeting a held, untaken request leaves it in place.
    a_r8_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !rdy && hint_ok |=> vld && $stable(addr));

    // R10: reset empties the slot.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !vld);

endmodule

// File: rtl/touch_prefetch_issuer.sv
// Module: touch_prefetch_issuer
// Top of the cache-touch prefetch issuer: decode, address forming, fault
// filtering and the single-entry request slot. Assumes translation results
// arrive in the same cycle as the instruction. Faults drop the hint silently.
module touch_prefetch_issuer
    import touch_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned LINE_BYTES = 128,
    parameter int unsigned PRI_TOUCH  = 31,
    parameter int unsigned XO_RD      = 278,
    parameter int unsigned XO_ST      = 246
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_vld,
    input  logic [31:0]       insn_word,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic              xlate_unmapped,
    input  logic              xlate_protect,
    input  logic              pf_rdy,
    output logic              pf_vld,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              pf_excl
);

    localparam int unsigned OFFS_W = $clog2(LINE_BYTES);

    hint_dec_t         dec;
    logic [ADDR_W-1:0] line_addr;
    logic              fault;
    logic              hint_ok;
    logic              hint_excl;

    touch_decode #(
        .PRI_TOUCH (PRI_TOUCH),
        .XO_RD     (XO_RD),
        .XO_ST     (XO_ST)
    ) dec_i (
        .vld  (insn_vld),
        .word (insn_word),
        .dec  (dec)
    );

    touch_ea #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) ea_i (
        .base_zero (dec.ra_is_zero),
        .base_val  (opnd_a),
        .index_val (opnd_b),
        .line_addr (line_addr)
    );

    // Filter faulting hints and pick the fill state from the intent.
    always_comb begin
        fault     = xlate_unmapped || xlate_protect;
        hint_ok   = (dec.kind != HINT_NONE) && !fault;
        hint_excl = (dec.kind == HINT_STORE);
    end

    touch_req_slot #(
        .ADDR_W (ADDR_W)
    ) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hint_ok   (hint_ok),
        .hint_addr (line_addr),
        .hint_excl (hint_excl),
        .rdy       (pf_rdy),
        .vld       (pf_vld),
        .addr      (pf_addr),
        .excl      (pf_excl)
    );

    // R5: every request is line aligned.
    generate
        if (OFFS_W > 0) begin : g_align_chk
            a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
                pf_vld |-> pf_addr[OFFS_W-1:0] == '0);
        end
    endgenerate

    // R6: a faulting instruction into a free slot leaves it empty.
    a_r6_fault_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_unmapped || xlate_protect) && (!pf_vld || pf_rdy) |=> !pf_vld);

    // R11: no instruction and a free slot means no request next cycle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld && (!pf_vld || pf_rdy) |=> !pf_vld);

    // R1: a store hint accepted into a free slot asks for exclusive state.
    a_r1_store_excl: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld && insn_word[31:26] == 6'd31 && insn_word[10:1] == 10'd246
        && !xlate_unmapped && !xlate_protect && (!pf_vld || pf_rdy)
        |=> pf_vld && pf_excl);

endmodule

// File: tb/touch_prefetch_issuer_tb.sv
// Bench: sweeps opcode fields and register numbers, then exercises the
// request slot collision cases; expected values are computed here.
module touch_prefetch_issuer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        insn_vld;
    logic [31:0] insn_word;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic        xlate_unmapped;
    logic        xlate_protect;
    logic        pf_rdy;
    logic        pf_vld;
    logic [63:0] pf_addr;
    logic        pf_excl;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    touch_prefetch_issuer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .insn_vld       (insn_vld),
        .insn_word      (insn_word),
        .opnd_a         (opnd_a),
        .opnd_b         (opnd_b),
        .xlate_unmapped (xlate_unmapped),
        .xlate_protect  (xlate_protect),
        .pf_rdy         (pf_rdy),
        .pf_vld         (pf_vld),
        .pf_addr        (pf_addr),
        .pf_excl        (pf_excl)
    );

    function automatic logic [31:0] mk_word(int pri, int rt, int ra, int rb, int xo, int rc);
        return {pri[5:0], rt[4:0], ra[4:0], rb[4:0], xo[9:0], rc[0]};
    endfunction

    function automatic logic [63:0] exp_addr(logic [31:0] w, logic [63:0] a, logic [63:0] b);
        logic [63:0] base = (w[20:16] == 5'd0) ? 64'd0 : a;
        return (base + b) & ~64'd127;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one word for one cycle, then check the result half a cycle after the load edge.
    task automatic issue_check(string req, logic [31:0] w, logic [63:0] a, logic [63:0] b,
                               logic um, logic pr);
        logic is_hint = w[31:26] == 6'd31 && (w[10:1] == 10'd246 || w[10:1] == 10'd278);
        logic take    = is_hint && !um && !pr;
        insn_vld = 1'b1; insn_word = w; opnd_a = a; opnd_b = b;
        xlate_unmapped = um; xlate_protect = pr;
        @(negedge clk);
        insn_vld = 1'b0; xlate_unmapped = 1'b0; xlate_protect = 1'b0;
        check(req, {63'd0, pf_vld}, {63'd0, take});
        if (take) begin
            check(req, pf_addr, exp_addr(w, a, b));
            check(req, {63'd0, pf_excl}, {63'd0, w[10:1] == 10'd246});
        end
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        rst_n = 1'b0; insn_vld = 1'b0; insn_word = '0; opnd_a = '0; opnd_b = '0;
        xlate_unmapped = 1'b0; xlate_protect = 1'b0; pf_rdy = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset state", {63'd0, pf_vld}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: garbage with valid low
        insn_word = 32'h7c0001ec; opnd_b = 64'h1000;
        @(negedge clk);
        @(negedge clk);
        check("R11 idle ignored", {63'd0, pf_vld}, 64'd0);

        // R1/R2/R3: every extended opcode under primary 31
        for (int xo = 0; xo < 1024; xo++) begin
            a = 64'h9E3779B97F4A7C15 * (xo + 1);
            b = 64'hC2B2AE3D27D4EB4F * (xo + 7);
            issue_check("R1/R2/R3 xo sweep", mk_word(31, xo % 32, 3, 4, xo, xo % 2), a, b, 1'b0, 1'b0);
        end
        // R3: every primary under both touch opcodes
        for (int p = 0; p < 64; p++) begin
            issue_check("R3 pri sweep st", mk_word(p, 0, 1, 2, 246, 0), 64'h1234_5678_9abc_def0, 64'h77, 1'b0, 1'b0);
            issue_check("R3 pri sweep rd", mk_word(p, 0, 1, 2, 278, 0), 64'h1234_5678_9abc_def0, 64'h77, 1'b0, 1'b0);
        end
        // R4/R5: every RA number, both hints; R9 with RT and Rc varied
        for (int ra = 0; ra < 32; ra++) begin
            a = 64'hFFFF_FFFF_FFFF_FF80 + ra * 64'h135;
            b = 64'h0000_0000_0000_00C0 + ra * 64'h2F1;
            issue_check("R4/R5 ra sweep st", mk_word(31, 31 - ra, ra, ra, 246, ra % 2), a, b, 1'b0, 1'b0);
            issue_check("R4/R5/R9 ra sweep rd", mk_word(31, ra, ra, 5, 278, 1), a, b, 1'b0, 1'b0);
        end
        // R1 exact encoding with RA=0: address is RB alone
        issue_check("R1 R4 base word", 32'h7c0001ec, 64'hDEAD_BEEF_0000_0000, 64'h0000_0000_0000_12FF, 1'b0, 1'b0);
        check("R4 ra0 addr", pf_addr, 64'h0000_0000_0000_1280);
        // R6: both fault kinds, both hints
        issue_check("R6 unmapped st", mk_word(31, 0, 2, 3, 246, 0), 64'h4000, 64'h80, 1'b1, 1'b0);
        issue_check("R6 protect rd", mk_word(31, 0, 2, 3, 278, 0), 64'h4000, 64'h80, 1'b0, 1'b1);
        issue_check("R6 both st", mk_word(31, 0, 0, 3, 246, 0), 64'h4000, 64'h80, 1'b1, 1'b1);

        // R7/R8: held request, dropped collision, replace-on-accept
        pf_rdy = 1'b0;
        insn_vld = 1'b1; insn_word = mk_word(31, 0, 1, 2, 246, 0);
        opnd_a = 64'h1_0000; opnd_b = 64'h1FF;
        @(negedge clk);
        insn_word = mk_word(31, 0, 1, 2, 278, 0); opnd_a = 64'h9_0000; opnd_b = 64'h0;
        check("R7 first appears", {63'd0, pf_vld}, 64'd1);
        check("R7 first addr", pf_addr, 64'h1_0180);
        @(negedge clk);
        insn_vld = 1'b0;
        check("R8 collision dropped addr", pf_addr, 64'h1_0180);
        check("R8 collision dropped excl", {63'd0, pf_excl}, 64'd1);
        repeat (3) @(negedge clk);
        check("R7 held stable", pf_addr, 64'h1_0180);
        check("R7 held valid", {63'd0, pf_vld}, 64'd1);
        pf_rdy = 1'b1;
        insn_vld = 1'b1; insn_word = mk_word(31, 0, 1, 2, 278, 0); opnd_a = 64'h5_0000; opnd_b = 64'h7F;
        @(negedge clk);
        insn_vld = 1'b0;
        check("R8 replace on accept vld", {63'd0, pf_vld}, 64'd1);
        check("R8 replace on accept addr", pf_addr, 64'h5_0000);
        check("R8 replace on accept excl", {63'd0, pf_excl}, 64'd0);
        @(negedge clk);
        check("R7 retired after accept", {63'd0, pf_vld}, 64'd0);

        // R10: reset clears a held request
        pf_rdy = 1'b0;
        insn_vld = 1'b1; insn_word = 32'h7c0001ec; opnd_b = 64'h300;
        @(negedge clk);
        insn_vld = 1'b0;
        check("R10 pending before reset", {63'd0, pf_vld}, 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset cleared", {63'd0, pf_vld}, 64'd0);
        pf_rdy = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule